// File: doc/BRIEF.md
# Keyed-Toggle Watchdog Timer

This block is a bus-clocked watchdog with a single 32-bit control word and a 24-bit threshold word. Software arms and services it by writing two-bit command codes. A code is honoured only when a write holding the value 1 in that field is followed directly by a control write holding 2 in the same field. One field flips the timer between running and stopped. The other field restarts the countdown while the timer runs.

Each command write carries a 24-bit reload figure in its low bits. The figure is the upper part of a 32-bit cycle count, so the countdown starts at the figure times 256 and drops by one on every clock. When a running countdown sits at zero, a reset pulse of fixed length is driven out and the timer stops itself. A threshold word sets an earlier warning point. When the count passes that point, a sticky interrupt flag rises. Reading the control word clears the flag, and so does an accepted restart.

Top module: `wdt_kwd_top`

## Requirements
- R1: After reset the timer is stopped, both read words are 0, and the reset pulse and interrupt outputs are low.
- R2: A control write (address 0) with bits 25:24 = 1, followed by the next control write with bits 25:24 = 2, toggles the running state on the clock edge of the second write. Bit 31 of the control read word is 1 exactly while the timer runs.
- R3: A control write whose bits 25:24 hold 0 or 3 clears the pending key of that field, and so does a write of 2 that has no directly preceding 1. Such a write changes nothing, and a following write of 2 is not accepted. The same rule applies to bits 27:26.
- R4: On the edge where the timer starts, the count loads that write's bits 23:0 shifted left by 8. The control read word shows bits 31:8 of the count in its bits 23:0.
- R5: While the timer runs and the count is nonzero, the count falls by 1 per clock. On the edge after a running count is seen at zero, the timer stops and the reset output goes high for exactly RST_CYCLES cycles.
- R6: While the timer runs, a completed key on bits 27:26 (1, then 2) reloads the count from that write's bits 23:0 shifted left by 8, and clears the interrupt flag.
- R7: While the timer is stopped, the count holds its value and a completed key on bits 27:26 has no effect.
- R8: A write to address 1 stores bits 23:0 as the threshold, and address 1 reads it back. When the threshold is nonzero and a running count equals the threshold shifted left by 8, the interrupt output and bit 30 of the control read word rise on the next edge and stay high.
- R9: A read of address 0 clears the interrupt flag on that clock edge.
- R10: A second completed enable key stops a running timer, and the count then freezes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the countdown clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| rd_en_i | input | 1 | Read strobe (clears the flag when it reads address 0) |
| addr_i | input | 1 | Word select: 0 = control/status, 1 = threshold |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for the selected word (combinational) |
| wdt_rst_o | output | 1 | Timeout reset pulse |
| irq_o | output | 1 | Threshold interrupt flag |

## Verification
The bench attacks broken key sequences: a 1 followed by a 0 or a 3 and then a 2, and a lone 2. A design that keeps the key armed across such writes would flip the timer when it should not. It also issues a restart while the timer is stopped. A design that ignores the running state there would change a frozen count. Expiry is timed to the cycle and the pulse length is counted. This catches off-by-one errors in the zero test or the pulse counter. The threshold crossing and its clearing by a read or a restart are checked every cycle against a bench model, so a flag that is lost, set late, or not sticky shows up at once.

// File: rtl/wdt_kwd_pkg.sv
package wdt_kwd_pkg;

   localparam int KEY_W = 2;

   typedef enum logic [KEY_W-1:0] {
      KEY_IDLE = 2'd0,
      KEY_ARM  = 2'd1,
      KEY_FIRE = 2'd2,
      KEY_JUNK = 2'd3
   } key_code_e;

   // index of each command field in the field array
   localparam int FLD_TOG = 0;
   localparam int FLD_RLD = 1;
   localparam int N_FLD   = 2;

endpackage

// File: rtl/wdt_kwd_key.sv
module wdt_kwd_key
   import wdt_kwd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [KEY_W-1:0] code_i,
   output logic             fire_o
);

   logic      armed_q;
   key_code_e code;

   assign code   = key_code_e'(code_i);
   assign fire_o = wr_i && (code == KEY_FIRE) && armed_q;

   // any control write re-decides the pending key: only an ARM code keeps it
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (wr_i) begin
         armed_q <= (code == KEY_ARM);
      end
   end

endmodule

// File: rtl/wdt_kwd_count.sv
module wdt_kwd_count #(
   parameter int CNT_W      = 32,
   parameter int RLD_W      = 24,
   parameter int RST_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tog_i,
   input  logic             rld_i,
   input  logic [RLD_W-1:0] load_i,
   output logic             en_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             rst_pulse_o
);

   localparam int SHIFT  = CNT_W - RLD_W;
   localparam int RSTC_W = $clog2(RST_CYCLES + 1);
   localparam logic [RSTC_W-1:0] RSTC_INIT = RSTC_W'(RST_CYCLES);
   localparam logic [CNT_W-1:0]  CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [RSTC_W-1:0] RSTC_ONE  = {{(RSTC_W-1){1'b0}}, 1'b1};

   logic              en_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [RSTC_W-1:0] pulse_q;
   logic [CNT_W-1:0]  load_full;
   logic              expire;
   logic              start;

   assign load_full = {load_i, {SHIFT{1'b0}}};
   assign expire    = en_q && (cnt_q == '0);
   assign start     = tog_i && !en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (tog_i) begin
         en_q <= !en_q;
      end else if (expire) begin
         en_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start || rld_i) begin
         cnt_q <= load_full;
      end else if (en_q && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q <= '0;
      end else if (expire) begin
         pulse_q <= RSTC_INIT;
      end else if (pulse_q != '0) begin
         pulse_q <= pulse_q - RSTC_ONE;
      end
   end

   assign en_o        = en_q;
   assign cnt_o       = cnt_q;
   assign rst_pulse_o = (pulse_q != '0);

endmodule

// File: rtl/wdt_kwd_irq.sv
module wdt_kwd_irq #(
   parameter int CNT_W  = 32,
   parameter int RLD_W  = 24,
   parameter bit IRQ_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [RLD_W-1:0] thr_i,
   input  logic             clr_i,
   output logic             flag_o
);

   localparam int SHIFT = CNT_W - RLD_W;

   generate
      if (IRQ_EN) begin : g_irq
         logic flag_q;
         logic hit;

         assign hit = en_i && (thr_i != '0) && (cnt_i == {thr_i, {SHIFT{1'b0}}});

         // a new crossing wins over a clear in the same cycle
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (hit) begin
               flag_q <= 1'b1;
            end else if (clr_i) begin
               flag_q <= 1'b0;
            end
         end
         assign flag_o = flag_q;
      end else begin : g_no_irq
         logic unused;
         assign unused = ^{en_i, cnt_i, thr_i, clr_i, clk, rst_n};
         assign flag_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/wdt_kwd_top.sv
module wdt_kwd_top
   import wdt_kwd_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 32,
   parameter int RLD_W      = 24,
   parameter int TOG_LSB    = 24,
   parameter int RLD_LSB    = 26,
   parameter int FLAG_BIT   = 30,
   parameter int STAT_BIT   = 31,
   parameter int RST_CYCLES = 16,
   parameter bit IRQ_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic              addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              wdt_rst_o,
   output logic              irq_o
);

   localparam int SHIFT = CNT_W - RLD_W;
   localparam int FLD_LSB [N_FLD] = '{TOG_LSB, RLD_LSB};

   // elaboration-time parameter checks
   generate
      if (RLD_W >= CNT_W) begin : g_err_w
         $error("reload field must be narrower than the counter");
      end
      if (RLD_W > TOG_LSB || RLD_W > RLD_LSB) begin : g_err_ovl
         $error("command fields overlap the reload field");
      end
      if (TOG_LSB + KEY_W > DATA_W || RLD_LSB + KEY_W > DATA_W) begin : g_err_fld
         $error("command field outside the data word");
      end
      if (STAT_BIT >= DATA_W || FLAG_BIT >= DATA_W || STAT_BIT == FLAG_BIT) begin : g_err_stat
         $error("status bit placement invalid");
      end
      if (RST_CYCLES < 1) begin : g_err_rst
         $error("reset pulse needs at least one cycle");
      end
   endgenerate

   logic              ctrl_wr;
   logic [N_FLD-1:0]  fire;
   logic              en_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [RLD_W-1:0]  thr_q;
   logic              irq_flag;
   logic              rld_apply;
   logic              irq_clr;
   logic [DATA_W-1:0] status;

   assign ctrl_wr = wr_en_i && !addr_i;

   generate
      for (genvar g = 0; g < N_FLD; g++) begin : g_key
         wdt_kwd_key u_key (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (ctrl_wr),
            .code_i (wr_data_i[FLD_LSB[g] +: KEY_W]),
            .fire_o (fire[g])
         );
      end
   endgenerate

   // restart acts only on a running timer that this write does not stop
   assign rld_apply = fire[FLD_RLD] && en_q && !fire[FLD_TOG];

   wdt_kwd_count #(
      .CNT_W      (CNT_W),
      .RLD_W      (RLD_W),
      .RST_CYCLES (RST_CYCLES)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .tog_i       (fire[FLD_TOG]),
      .rld_i       (rld_apply),
      .load_i      (wr_data_i[RLD_W-1:0]),
      .en_o        (en_q),
      .cnt_o       (cnt_q),
      .rst_pulse_o (wdt_rst_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q <= '0;
      end else if (wr_en_i && addr_i) begin
         thr_q <= wr_data_i[RLD_W-1:0];
      end
   end

   assign irq_clr = (rd_en_i && !addr_i) || rld_apply;

   wdt_kwd_irq #(
      .CNT_W  (CNT_W),
      .RLD_W  (RLD_W),
      .IRQ_EN (IRQ_EN)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_q),
      .cnt_i  (cnt_q),
      .thr_i  (thr_q),
      .clr_i  (irq_clr),
      .flag_o (irq_flag)
   );

   always_comb begin
      status                = '0;
      status[RLD_W-1:0]     = cnt_q[CNT_W-1:SHIFT];
      status[FLAG_BIT]      = irq_flag;
      status[STAT_BIT]      = en_q;
   end

   assign rd_data_o = addr_i ? {{(DATA_W-RLD_W){1'b0}}, thr_q} : status;
   assign irq_o     = irq_flag;

endmodule

// File: rtl/wdt_kwd_chk.sv
module wdt_kwd_chk #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 32,
   parameter int RLD_W   = 24,
   parameter int TOG_LSB = 24,
   parameter bit IRQ_EN  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_i,
   input logic              addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [1:0]        fire,
   input logic              rld_apply,
   input logic              en_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [RLD_W-1:0]  thr_q,
   input logic              irq_o,
   input logic              wdt_rst_o
);

   localparam int SHIFT = CNT_W - RLD_W;

   // R2: an accepted enable key flips the running state
   p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire[0] |=> (en_q != $past(en_q)));

   // R3: a control write without the ARM code leaves no key for the next write
   p_key_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !addr_i && (wr_data_i[TOG_LSB +: 2] != 2'd1)) |=> !fire[0]);

   // R5: one step down per clock while running
   p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && (cnt_q != '0) && !rld_apply && !(fire[0] && !en_q))
      |=> (cnt_q == $past(cnt_q) - 1));

   // R5: a running zero count fires the reset and stops the timer
   p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && (cnt_q == '0)) |=> (wdt_rst_o && !en_q));

   // R7: a stopped timer freezes unless it is being started
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !fire[0]) |=> $stable(cnt_q));

   // R8: reaching the threshold raises the flag on the next edge
   p_thresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (IRQ_EN && en_q && (thr_q != '0) && (cnt_q == {thr_q, {SHIFT{1'b0}}})) |=> irq_o);

endmodule

bind wdt_kwd_top wdt_kwd_chk #(
   .DATA_W  (DATA_W),
   .CNT_W   (CNT_W),
   .RLD_W   (RLD_W),
   .TOG_LSB (TOG_LSB),
   .IRQ_EN  (IRQ_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en_i   (wr_en_i),
   .addr_i    (addr_i),
   .wr_data_i (wr_data_i),
   .fire      (fire),
   .rld_apply (rld_apply),
   .en_q      (en_q),
   .cnt_q     (cnt_q),
   .thr_q     (thr_q),
   .irq_o     (irq_o),
   .wdt_rst_o (wdt_rst_o)
);

// File: tb/tb_wdt_kwd_top.sv
module tb_wdt_kwd_top;

   localparam int CLK_PERIOD = 10;
   localparam int RST_CYC    = 16;
   localparam int WD_LIMIT   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic        addr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;
   logic        wdt_rst;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_kwd_top #(.RST_CYCLES(RST_CYC)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .rd_en_i   (rd_en),
      .addr_i    (addr),
      .wr_data_i (wdata),
      .rd_data_o (rd_data),
      .wdt_rst_o (wdt_rst),
      .irq_o     (irq)
   );

   // ---------------- bench model built from the requirements ----------------
   bit          m_en, m_irq;
   logic [31:0] m_cnt;
   logic [23:0] m_thr;
   bit          m_arm_t, m_arm_r;
   int          m_pulse;

   function automatic logic [31:0] exp_read(input logic a);
      if (a) return {8'h00, m_thr};
      return {m_en, m_irq, 6'b0, m_cnt[31:8]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_irq = 0; m_cnt = '0; m_thr = '0;
         m_arm_t = 0; m_arm_r = 0; m_pulse = 0;
      end else begin
         bit cw, ft, fr, ex, hit, rl;
         cw  = wr_en && !addr;
         ft  = cw && (wdata[25:24] == 2'd2) && m_arm_t;
         fr  = cw && (wdata[27:26] == 2'd2) && m_arm_r;
         ex  = m_en && (m_cnt == 0);
         hit = m_en && (m_thr != 0) && (m_cnt == {m_thr, 8'h00});
         rl  = fr && m_en && !ft;
         if (cw) begin
            m_arm_t = (wdata[25:24] == 2'd1);
            m_arm_r = (wdata[27:26] == 2'd1);
         end
         if (hit) m_irq = 1;
         else if ((rd_en && !addr) || rl) m_irq = 0;
         if (ex) m_pulse = RST_CYC;
         else if (m_pulse != 0) m_pulse = m_pulse - 1;
         if ((ft && !m_en) || rl) m_cnt = {wdata[23:0], 8'h00};
         else if (m_en && m_cnt != 0) m_cnt = m_cnt - 1;
         if (ft) m_en = !m_en;
         else if (ex) m_en = 0;
         if (wr_en && addr) m_thr = wdata[23:0];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, sampled on the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [31:0] e;
         e = exp_read(addr);
         if (!addr) begin
            chk("R2 status bit", {31'b0, rd_data[31]}, {31'b0, e[31]});
            chk("R5 count field", {8'b0, rd_data[23:0]}, {8'b0, e[23:0]});
            chk("R9 flag bit", {31'b0, rd_data[30]}, {31'b0, e[30]});
         end else begin
            chk("R8 threshold word", rd_data, e);
         end
         chk("R5 reset output", {31'b0, wdt_rst}, {31'b0, m_pulse != 0});
         chk("R8 irq output", {31'b0, irq}, {31'b0, m_irq});
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr_ctrl(input logic [1:0] rl, input logic [1:0] tg, input logic [23:0] v);
      @(negedge clk); #1;
      wr_en = 1; addr = 0; wdata = {4'b0, rl, tg, v};
      @(negedge clk); #1;
      wr_en = 0;
   endtask

   task automatic wr_thr(input logic [23:0] v);
      @(negedge clk); #1;
      wr_en = 1; addr = 1; wdata = {8'b0, v};
      @(negedge clk); #1;
      wr_en = 0; addr = 0;
   endtask

   task automatic rd_ctrl();
      @(negedge clk); #1;
      rd_en = 1; addr = 0;
      @(negedge clk); #1;
      rd_en = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WD_LIMIT);
         finish_run();
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] held;
      int plen, waitc;
      void'($urandom(32'd2718));
      idle(3);
      // R1: reset state
      chk("R1 control word", rd_data, 32'h0);
      chk("R1 reset out", {31'b0, wdt_rst}, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      @(negedge clk); #1; rst_n = 1; addr = 1;
      @(negedge clk); #1;
      chk("R1 threshold word", rd_data, 32'h0);
      addr = 0;

      // R2 / R4: start with reload figure 2
      wr_ctrl(2'd0, 2'd1, 24'd2);
      wr_ctrl(2'd0, 2'd2, 24'd2);
      chk("R2 running after key", {31'b0, rd_data[31]}, 32'h1);
      chk("R4 loaded count", {8'b0, rd_data[23:0]}, 32'd2);

      // R3: broken sequences must not stop it
      wr_ctrl(2'd0, 2'd1, 24'd2);
      wr_ctrl(2'd0, 2'd0, 24'd2);
      wr_ctrl(2'd0, 2'd2, 24'd2);
      chk("R3 zero breaks key", {31'b0, rd_data[31]}, 32'h1);
      wr_ctrl(2'd0, 2'd1, 24'd2);
      wr_ctrl(2'd0, 2'd3, 24'd2);
      wr_ctrl(2'd0, 2'd2, 24'd2);
      chk("R3 three breaks key", {31'b0, rd_data[31]}, 32'h1);
      wr_ctrl(2'd0, 2'd2, 24'd2);
      chk("R3 lone two ignored", {31'b0, rd_data[31]}, 32'h1);

      // R6: restart with a new figure
      idle(10);
      wr_ctrl(2'd1, 2'd0, 24'd7);
      wr_ctrl(2'd2, 2'd0, 24'd5);
      chk("R6 restart count", {8'b0, rd_data[23:0]}, 32'd5);

      // R10 / R7: stop, then count must freeze and restart be ignored
      wr_ctrl(2'd0, 2'd1, 24'd0);
      wr_ctrl(2'd0, 2'd2, 24'd0);
      chk("R10 stopped", {31'b0, rd_data[31]}, 32'h0);
      held = rd_data;
      idle(40);
      chk("R7 frozen count", rd_data, held);
      wr_ctrl(2'd1, 2'd0, 24'd9);
      wr_ctrl(2'd2, 2'd0, 24'd9);
      chk("R7 restart ignored", rd_data, held);

      // R8 / R9: threshold 1, start with figure 2
      wr_thr(24'd1);
      wr_ctrl(2'd0, 2'd1, 24'd2);
      wr_ctrl(2'd0, 2'd2, 24'd2);
      idle(300);
      chk("R8 irq raised", {31'b0, irq}, 32'h1);
      chk("R8 flag bit", {31'b0, rd_data[30]}, 32'h1);
      rd_ctrl();
      chk("R9 cleared by read", {31'b0, irq}, 32'h0);

      // R5: expiry and pulse length
      waitc = 0;
      while (!wdt_rst && waitc < 2000) begin
         @(negedge clk); waitc++;
      end
      plen = 0;
      while (wdt_rst && plen < 100) begin
         plen++; @(negedge clk);
      end
      chk("R5 pulse length", plen, RST_CYC);
      chk("R5 stopped after expiry", {31'b0, rd_data[31]}, 32'h0);

      // random phase, checked by the per-cycle model comparison
      for (int i = 0; i < 6000; i++) begin
         int r;
         @(negedge clk); #1;
         wr_en = 0; rd_en = 0;
         r = $urandom % 100;
         if (r < 18) begin
            logic [1:0] t, l;
            t = ($urandom % 4 == 0) ? 2'($urandom) : 2'(1 + ($urandom % 2));
            l = ($urandom % 4 == 0) ? 2'($urandom) : 2'(1 + ($urandom % 2));
            wr_en = 1; addr = 0;
            wdata = {4'($urandom), l, t, 24'($urandom % 4)};
         end else if (r < 21) begin
            wr_en = 1; addr = 1; wdata = {8'($urandom), 24'($urandom % 4)};
         end else if (r < 26) begin
            rd_en = 1; addr = 0;
         end else begin
            addr = 1'($urandom);
         end
      end
      @(negedge clk); #1;
      wr_en = 0; rd_en = 0;
      idle(2);
      finish_run();
   end

endmodule